// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Programmable Flags

This block carries 36-bit words from a write clock domain to an unrelated read clock domain. By default it stores 512 words. The read side has an output register that fills itself, in the manner of a first-word-fall-through FIFO. Once a word is in memory, it is moved into that register without any read request. The word then waits on `rd_data` with `rd_valid` high until the reader takes it with `rd_en`.

Each side has a pair of status flags, and each flag is registered in its own clock domain.

- Read side: `rd_valid` says a word is presented. `rd_not_aempty` says the read-side level is above the almost-empty offset.
- Write side: `wr_ready` says there is room. `wr_not_afull` says the write-side level is below the almost-full threshold.

The pointers cross between domains as Gray code through a chain of at least two flip-flops. A flag that reports more data or more room therefore changes a few cycles late, and always on the safe side. Both offsets are sampled from input ports while the reset of their own domain is high.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `wr_rst` and `rd_rst` are high, `rd_valid` and `wr_ready` are 0. Once the resets are released with nothing written, and after the pointers have crossed, the flags are `rd_valid`=0, `rd_not_aempty`=0, `wr_ready`=1 and `wr_not_afull`=1.
- R2: A word written into an empty FIFO appears on `rd_data` with `rd_valid`=1, with `rd_en` held low the whole time.
- R3: Words leave in the order they were accepted, and none is lost, repeated or invented. A write is accepted on a `wr_clk` rising edge where `wr_en`=1 and `wr_ready`=1.
- R4: While `rd_valid`=1 and `rd_en`=0, `rd_data` and `rd_valid` hold their values. A rising edge with `rd_valid`=1 and `rd_en`=1 consumes the word. `rd_valid` only falls after such a consumption.
- R5: `rd_en` has no effect while `rd_valid`=0. A later word is still delivered exactly once.
- R6: A write attempted while `wr_ready`=0 is not stored.
- R7: The write-side level counts the words held in memory. The word in the output register has already freed its memory slot and is not counted. `wr_ready` is 0 exactly when the write-side level equals 2^ADDR_W. With no reads, 2^ADDR_W+1 words fit before `wr_ready` drops.
- R8: The read-side level counts the words in memory plus the word in the output register. Once settled, `rd_not_aempty` is 1 exactly when this level exceeds X, and it is never 1 while `rd_valid`=0.
- R9: Once settled, `wr_not_afull` is 0 exactly when the write-side level is at least 2^ADDR_W − Y. `wr_not_afull` is always 0 whenever `wr_ready` is 0.
- R10: `ae_offset` is sampled as X while `rd_rst` is high, and `af_offset` is sampled as Y while `wr_rst` is high. Changing either port afterwards has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| af_offset | input | ADDR_W | Almost-full offset Y, sampled during `wr_rst` |
| wr_ready | output | 1 | Room for at least one more word |
| wr_not_afull | output | 1 | Write-side level below 2^ADDR_W − Y |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Consume the presented word |
| ae_offset | input | ADDR_W | Almost-empty offset X, sampled during `rd_rst` |
| rd_data | output | DATA_W | Presented word |
| rd_valid | output | 1 | A word is presented on `rd_data` |
| rd_not_aempty | output | 1 | Read-side level above X |

## Verification
The bench builds the FIFO with ADDR_W=4, so the memory holds 16 words and the full condition is reached within seventeen writes. It keeps DATA_W at 36. The offsets are sampled as X=3 and Y=2, and both ports are then driven to zero. Both thresholds can therefore be stepped across one word at a time: level 3 to level 4 for almost-empty, and 13 to 14 memory words for almost-full. A threshold that followed the live ports would show at once. With the small depth, one run also covers the case where the output register holds an extra word beyond a full memory, a refused write at full, and reads issued against an empty FIFO.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    localparam int unsigned DEF_DATA_W = 36;
    localparam int unsigned DEF_ADDR_W = 9;
    localparam int unsigned MIN_SYNC   = 2;

    // Read-domain status pair
    typedef struct packed {
        logic valid;
        logic above_ae;
    } rd_flags_t;

    // Write-domain status pair
    typedef struct packed {
        logic ready;
        logic below_af;
    } wr_flags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) q[i] <= '0;
        end else begin
            q[0] <= din;
            for (int i = 1; i < int'(STAGES); i++) q[i] <= q[i-1];
        end
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/dcfifo_mem.sv
`timescale 1ns/1ps
module dcfifo_mem #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] af_off_in,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output wr_flags_t         flags
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned LVL_W = ADDR_W + 2;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0]  wbin, wbin_nxt, rbin, level_nxt;
    logic [ADDR_W-1:0] af_off;
    logic [LVL_W-1:0]  af_limit;
    logic              push;

    assign push      = wr_en & flags.ready;
    assign wbin_nxt  = wbin + PTR_W'(push);
    assign rbin      = PTR_W'(gray2bin(32'(rgray_sync)));
    assign level_nxt = wbin_nxt - rbin;
    assign af_limit  = LVL_W'(DEPTH) - LVL_W'(af_off);
    assign we        = push;
    assign waddr     = wbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            af_off <= af_off_in;
            flags  <= '0;
        end else begin
            wbin           <= wbin_nxt;
            wgray          <= PTR_W'(bin2gray(32'(wbin_nxt)));
            flags.ready    <= (level_nxt != PTR_W'(DEPTH));
            flags.below_af <= (LVL_W'(level_nxt) < af_limit);
        end
    end
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ae_off_in,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output rd_flags_t         flags
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned LVL_W = ADDR_W + 2;

    logic [PTR_W-1:0]  rbin, rbin_nxt, wbin, mem_lvl;
    logic [LVL_W-1:0]  lvl_nxt;
    logic [ADDR_W-1:0] ae_off;
    logic              load, valid_nxt;

    assign wbin      = PTR_W'(gray2bin(32'(wgray_sync)));
    assign mem_lvl   = wbin - rbin;
    // Prefetch when the register is empty or is being emptied this edge
    assign load      = (mem_lvl != '0) && (!flags.valid || rd_en);
    assign valid_nxt = load | (flags.valid & ~rd_en);
    assign rbin_nxt  = rbin + PTR_W'(load);
    assign lvl_nxt   = LVL_W'(wbin - rbin_nxt) + LVL_W'(valid_nxt);
    assign raddr     = rbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            ae_off <= ae_off_in;
            flags  <= '0;
            dout   <= '0;
        end else begin
            rbin           <= rbin_nxt;
            rgray          <= PTR_W'(bin2gray(32'(rbin_nxt)));
            flags.valid    <= valid_nxt;
            flags.above_ae <= (lvl_nxt > LVL_W'(ae_off));
            if (load) dout <= mem_rdata;
        end
    end
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo
    import dcfifo_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned SYNC_STAGES = MIN_SYNC
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] af_offset,
    output logic              wr_ready,
    output logic              wr_not_afull,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ae_offset,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_not_aempty
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned STG   = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

    logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              we;
    wr_flags_t         wflags;
    rd_flags_t         rflags;

    dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dcfifo_sync #(.W(PTR_W), .STAGES(STG)) r2w_i (
        .clk(wr_clk), .rst(wr_rst), .din(rgray), .dout(rgray_s)
    );

    dcfifo_sync #(.W(PTR_W), .STAGES(STG)) w2r_i (
        .clk(rd_clk), .rst(rd_rst), .din(wgray), .dout(wgray_s)
    );

    dcfifo_wr_ctrl #(.ADDR_W(ADDR_W)) wctl_i (
        .clk(wr_clk), .rst(wr_rst), .af_off_in(af_offset), .wr_en(wr_en),
        .rgray_sync(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .flags(wflags)
    );

    dcfifo_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rctl_i (
        .clk(rd_clk), .rst(rd_rst), .ae_off_in(ae_offset), .rd_en(rd_en),
        .wgray_sync(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr),
        .rgray(rgray), .dout(rd_data), .flags(rflags)
    );

    assign wr_ready      = wflags.ready;
    assign wr_not_afull  = wflags.below_af;
    assign rd_valid      = rflags.valid;
    assign rd_not_aempty = rflags.above_ae;
endmodule

// File: rtl/dual_clock_fifo_chk.sv
`timescale 1ns/1ps
module dual_clock_fifo_chk #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 9
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_ready,
    input logic              wr_not_afull,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_not_aempty
);
    // R4: an unconsumed word stays put
    assert_word_held_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    // R4: valid drops only after a consuming read
    assert_drop_after_read_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_valid) |-> $past(rd_en));

    // R8: above the almost-empty level implies a word is presented
    assert_aempty_needs_valid_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_not_aempty |-> rd_valid);

    // R9: a full FIFO is also almost full
    assert_full_is_afull_R9: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_ready |-> !wr_not_afull);
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dual_clock_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb_top;
    localparam int DW = 36;
    localparam int AW = 4;
    localparam int XOFF = 3;
    localparam int YOFF = 2;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst = 1, rd_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] af_offset = AW'(YOFF);
    logic [AW-1:0] ae_offset = AW'(XOFF);
    logic          wr_ready, wr_not_afull, rd_valid, rd_not_aempty;
    logic [DW-1:0] rd_data;

    int            errors = 0, checks = 0, popped = 0;
    bit            drain = 0;
    logic [DW-1:0] sb [$];

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;

    dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .af_offset(af_offset), .wr_ready(wr_ready), .wr_not_afull(wr_not_afull),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .ae_offset(ae_offset),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_not_aempty(rd_not_aempty)
    );

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(input int i);
        return DW'(i) * 36'h0_0123_4567 + 36'h9_0000_0001;
    endfunction

    // Driver: present a word until accepted, then log it as expected
    task automatic put(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en   = 1;
        wr_data = d;
        while (!wr_ready) @(negedge wr_clk);
        sb.push_back(d);
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge rd_clk);
    endtask

    // Monitor: decides rd_en for the next edge and scores consumed words
    always @(negedge rd_clk) begin
        logic          go;
        logic [DW-1:0] exp;
        go = drain;
        if (go && rd_valid) begin
            if (sb.size() == 0) begin
                check(0, "R3 R6 extra word", rd_data, '0);
            end else begin
                exp = sb.pop_front();
                check(rd_data == exp, "R3 order", rd_data, exp);
                popped++;
            end
        end
        rd_en = go;
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        check(0, "R3 watchdog expired", '0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (6) @(negedge wr_clk);
        check(rd_valid == 0, "R1 rd_valid in reset", DW'(rd_valid), '0);
        check(wr_ready == 0, "R1 wr_ready in reset", DW'(wr_ready), '0);
        @(negedge wr_clk);
        wr_rst = 0;
        rd_rst = 0;
        af_offset = '0;  // R10: later changes must be ignored
        ae_offset = '0;
        settle();
        check(rd_valid == 0,      "R1 rd_valid idle",      DW'(rd_valid), 0);
        check(rd_not_aempty == 0, "R1 rd_not_aempty idle", DW'(rd_not_aempty), 0);
        check(wr_ready == 1,      "R1 wr_ready idle",      DW'(wr_ready), 1);
        check(wr_not_afull == 1,  "R1 wr_not_afull idle",  DW'(wr_not_afull), 1);

        put(word(1));
        settle();
        check(rd_valid == 1,      "R2 fall-through valid", DW'(rd_valid), 1);
        check(rd_data == word(1), "R2 fall-through data",  rd_data, word(1));
        check(rd_not_aempty == 0, "R8 R10 level 1 vs X=3", DW'(rd_not_aempty), 0);
        repeat (20) @(negedge rd_clk);
        check(rd_valid == 1 && rd_data == word(1), "R4 word held", rd_data, word(1));

        put(word(2));
        put(word(3));
        settle();
        check(rd_not_aempty == 0, "R8 level 3", DW'(rd_not_aempty), 0);
        put(word(4));
        settle();
        check(rd_not_aempty == 1, "R8 level 4", DW'(rd_not_aempty), 1);

        for (int i = 5; i <= 14; i++) put(word(i));
        settle();
        check(wr_not_afull == 1, "R9 13 in memory", DW'(wr_not_afull), 1);
        put(word(15));
        settle();
        check(wr_not_afull == 0, "R9 R10 14 in memory", DW'(wr_not_afull), 0);
        check(wr_ready == 1,     "R7 14 in memory",     DW'(wr_ready), 1);
        put(word(16));
        settle();
        check(wr_ready == 1, "R7 15 in memory", DW'(wr_ready), 1);
        put(word(17));
        settle();
        check(wr_ready == 0, "R7 16 in memory", DW'(wr_ready), 0);

        // R6: refused write while full
        @(negedge wr_clk);
        wr_en   = 1;
        wr_data = 36'hB_AD0B_AD0B;
        repeat (4) @(negedge wr_clk);
        wr_en = 0;
        check(wr_ready == 0, "R6 still full", DW'(wr_ready), 0);

        drain = 1;
        while (sb.size() != 0) @(negedge rd_clk);
        settle();
        check(popped == 17,       "R3 all words out",   DW'(popped), 17);
        check(rd_valid == 0,      "R4 empty after read", DW'(rd_valid), 0);
        check(rd_not_aempty == 0, "R8 empty level",     DW'(rd_not_aempty), 0);
        check(wr_ready == 1,      "R7 room again",      DW'(wr_ready), 1);
        check(wr_not_afull == 1,  "R9 drained",         DW'(wr_not_afull), 1);

        // R5: rd_en kept high on an empty FIFO
        repeat (20) @(negedge rd_clk);
        check(rd_valid == 0, "R5 no word from empty", DW'(rd_valid), 0);
        put(word(18));
        settle();
        check(popped == 18,    "R5 later word delivered once", DW'(popped), 18);
        check(sb.size() == 0,  "R5 scoreboard empty",          DW'(sb.size()), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule